// File: doc/BRIEF.md
# Reconfigurable Cellular Automaton Cipher / GF(2^m) Multiplier

This block is a row of `WIDTH` programmable cells that does one of two jobs, chosen by a mode input. In cipher mode every cell looks at its own bit and its two adjacent bits. It applies an XNOR-style elementary cellular-automaton rule named by a 2-bit code. The array turns one data block into its transformed value in a single clock. A cyclic rule register supplies the per-cell codes, and it rotates after every block, so successive blocks see successive transformations.

In multiplier mode the same cells become an XOR feedback chain. The chain forms a most-significant-bit-first polynomial-basis multiplier over GF(2^WIDTH). The reduction polynomial is held in a programmable register, so one instance serves any field of that width. A multiplication consumes one bit of the second operand per clock.

Both the rule word and the polynomial are written through a single configuration port. They keep their values until they are rewritten. A start strobe launches work, the result appears on the data output, and a one-cycle done flag marks it.

Top module: `pca_datapath`

## Requirements
- R1: After reset, `dout` is 0, `done` is 0, every cell's rule code is 00 and every polynomial coefficient is 0.
- R2: In cipher mode cell i computes, from input bit s=din_a[i], left bit l=din_a[i+1] and right bit r=din_a[i-1] (a missing neighbour at either end reads 0), code 00: ~s; code 01: ~(s^r); code 10: ~(l^s); code 11: s unchanged.
- R3: A cipher block is accepted on any edge where `start`=1, `mode_c`=1 and no multiply is running. Its result is on `dout` with `done`=1 right after that edge, and blocks may be issued on consecutive cycles.
- R4: Each accepted cipher block rotates the rule word by one cell: the new code of cell i is the old code of cell i-1, and cell 0 takes the old code of cell WIDTH-1.
- R5: When `cfg_we`=1, `cfg_sel`=0 loads the rule word from `cfg_data`, with the code of cell i in bits [2i+1:2i]. `cfg_sel`=1 loads the polynomial from `cfg_data[WIDTH-1:0]`, where bit i is the coefficient of x^i and x^WIDTH is implied. The value is used from the next edge on, and a rule write made in the same cycle as a rotation takes precedence.
- R6: With `mode_c`=0, an accepted `start` multiplies `din_a` by `din_b` modulo the loaded polynomial. The product is on `dout` with `done`=1 right after the WIDTH-th edge following the accepting edge.
- R7: While a multiply runs, `start` is ignored in both modes, whatever the data: the result, its timing and the rule word are unaffected.
- R8: `done` is high for exactly one cycle per result, and `dout` holds the last result until a new operation is accepted.
- R9: The mode is sampled only when `start` is accepted, so changes on `mode_c` during a multiply have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Configuration target: 0 rule word, 1 polynomial |
| cfg_data | input | 2*WIDTH | Configuration value |
| mode_c | input | 1 | 1 cipher mode, 0 multiplier mode |
| start | input | 1 | Launch strobe |
| din_a | input | WIDTH | Cipher block or first multiplicand |
| din_b | input | WIDTH | Second multiplicand |
| dout | output | WIDTH | Result |
| done | output | 1 | One-cycle result flag |

## Verification
The bench builds the block with WIDTH=4. This makes every polynomial with x^4 implied, paired with every operand pair, small enough to sweep: 16 x 256 multiplies, each compared with a carry-less product reduced arithmetically. The same width lets all 256 rule words be loaded and run through four consecutive blocks. This covers every code at both boundary cells and every rotation position against a bench model of the rules. Directed cases add start and mode changes in the middle of a multiply, and a rule write that collides with a rotation.

// File: rtl/pca_pkg.sv
package pca_pkg;

  typedef enum logic [1:0] {
    RULE_INV      = 2'b00,   // ~self
    RULE_INV_R    = 2'b01,   // ~(self ^ right)
    RULE_INV_L    = 2'b10,   // ~(left ^ self)
    RULE_PASS     = 2'b11    // self
  } rule_code_e;

  typedef enum logic {
    CFG_RULES = 1'b0,
    CFG_POLY  = 1'b1
  } cfg_tgt_e;

  localparam int CODE_W = 2;

endpackage

// File: rtl/pca_cfg_regs.sv
module pca_cfg_regs
  import pca_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int RW   = WIDTH * CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [RW-1:0]    cfg_data,
  input  logic             rotate,
  output logic [RW-1:0]    rules_o,
  output logic [WIDTH-1:0] poly_o
);

  logic [RW-1:0]    rules_q, rules_d;
  logic [WIDTH-1:0] poly_q, poly_d;
  logic             rules_en, poly_en;
  logic             wr_rules, wr_poly;

  always_comb begin
    wr_rules = cfg_we && (cfg_tgt_e'(cfg_sel) == CFG_RULES);
    wr_poly  = cfg_we && (cfg_tgt_e'(cfg_sel) == CFG_POLY);
    rules_en = wr_rules || rotate;
    poly_en  = wr_poly;
    if (wr_rules) rules_d = cfg_data;
    else          rules_d = {rules_q[RW-CODE_W-1:0], rules_q[RW-1:RW-CODE_W]};
    poly_d = cfg_data[WIDTH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rules_q <= '0;
      poly_q  <= '0;
    end else begin
      if (rules_en) rules_q <= rules_d;
      if (poly_en)  poly_q  <= poly_d;
    end
  end

  assign rules_o = rules_q;
  assign poly_o  = poly_q;

  // R5: without a write or a rotation, the rule word stays put
  p_rule_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !rotate) |=> $stable(rules_q));

  // R4: a rotation only moves codes around, never changes how many bits are set
  p_rule_rotate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate && !cfg_we) |=> ($countones(rules_q) == $countones($past(rules_q))));

  // R5: polynomial changes only on its own write
  p_poly_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_sel) |=> $stable(poly_q));

endmodule

// File: rtl/pca_cell.sv
module pca_cell
  import pca_pkg::*;
(
  input  logic       cipher_en,
  input  logic [1:0] code,
  input  logic       self_b,
  input  logic       left_b,
  input  logic       right_b,
  input  logic       feed_b,
  input  logic       top_b,
  input  logic       poly_b,
  input  logic       a_b,
  input  logic       bsel_b,
  output logic       nxt_b
);

  logic cipher_b;
  logic mult_b;

  always_comb begin
    unique case (rule_code_e'(code))
      RULE_INV:   cipher_b = ~(self_b ^ 1'b0);
      RULE_INV_R: cipher_b = ~(self_b ^ right_b);
      RULE_INV_L: cipher_b = ~(left_b ^ self_b);
      RULE_PASS:  cipher_b = self_b;
      default:    cipher_b = self_b;
    endcase
    mult_b = feed_b ^ (top_b & poly_b) ^ (bsel_b & a_b);
    nxt_b  = cipher_en ? cipher_b : mult_b;
  end

endmodule

// File: rtl/pca_cell_array.sv
module pca_cell_array
  import pca_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int RW   = WIDTH * CODE_W
) (
  input  logic             cipher_en,
  input  logic [RW-1:0]    rules,
  input  logic [WIDTH-1:0] blk,
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] poly,
  input  logic [WIDTH-1:0] mcand,
  input  logic             bsel,
  output logic [WIDTH-1:0] nxt
);

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_cell
      logic l_b, r_b, f_b;
      if (gi == WIDTH - 1) begin : g_top
        assign l_b = 1'b0;
      end else begin : g_mid_l
        assign l_b = blk[gi+1];
      end
      if (gi == 0) begin : g_bot
        assign r_b = 1'b0;
        assign f_b = 1'b0;
      end else begin : g_mid_r
        assign r_b = blk[gi-1];
        assign f_b = acc[gi-1];
      end
      pca_cell u_cell (
        .cipher_en (cipher_en),
        .code      (rules[gi*CODE_W +: CODE_W]),
        .self_b    (blk[gi]),
        .left_b    (l_b),
        .right_b   (r_b),
        .feed_b    (f_b),
        .top_b     (acc[WIDTH-1]),
        .poly_b    (poly[gi]),
        .a_b       (mcand[gi]),
        .bsel_b    (bsel),
        .nxt_b     (nxt[gi])
      );
    end
  endgenerate

endmodule

// File: rtl/pca_seq.sv
module pca_seq #(
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_c,
  input  logic [WIDTH-1:0] din_a,
  input  logic [WIDTH-1:0] din_b,
  output logic             cipher_fire,
  output logic             mul_load,
  output logic             busy,
  output logic [WIDTH-1:0] mcand,
  output logic             bsel,
  output logic             done
);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [WIDTH-1:0] a_q, a_d;
  logic [WIDTH-1:0] b_q, b_d;
  logic             done_q, done_d;
  logic             last_step;

  always_comb begin
    cipher_fire = start && mode_c && !busy_q;
    mul_load    = start && !mode_c && !busy_q;
    last_step   = busy_q && (cnt_q == CNT_W'(1));
    busy_d = busy_q;
    cnt_d  = cnt_q;
    a_d    = a_q;
    b_d    = b_q;
    if (mul_load) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(WIDTH);
      a_d    = din_a;
      b_d    = din_b;
    end else if (busy_q) begin
      cnt_d = cnt_q - CNT_W'(1);
      b_d   = {b_q[WIDTH-2:0], 1'b0};
      if (last_step) busy_d = 1'b0;
    end
    done_d = cipher_fire || last_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      if (mul_load) a_q <= a_d;
      if (mul_load || busy_q) b_q <= b_d;
      done_q <= done_d;
    end
  end

  assign busy  = busy_q;
  assign mcand = a_q;
  assign bsel  = b_q[WIDTH-1];
  assign done  = done_q;

  // R7: no cipher block is accepted while a multiply is in flight
  p_no_cipher_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !cipher_fire);

  // R7: the multiplicand cannot change during a multiply
  p_mcand_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(a_q));

endmodule

// File: rtl/pca_datapath.sv
module pca_datapath
  import pca_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int RW   = WIDTH * CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [RW-1:0]    cfg_data,
  input  logic             mode_c,
  input  logic             start,
  input  logic [WIDTH-1:0] din_a,
  input  logic [WIDTH-1:0] din_b,
  output logic [WIDTH-1:0] dout,
  output logic             done
);

  logic             rst_meta_q, rst_sync_q;
  logic [RW-1:0]    rules;
  logic [WIDTH-1:0] poly;
  logic             cipher_fire, mul_load, busy, bsel, done_int;
  logic [WIDTH-1:0] mcand;
  logic [WIDTH-1:0] acc_q, acc_d, cell_nxt;
  logic             acc_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pca_cfg_regs #(.WIDTH(WIDTH)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_data (cfg_data),
    .rotate   (cipher_fire),
    .rules_o  (rules),
    .poly_o   (poly)
  );

  pca_seq #(.WIDTH(WIDTH)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .start       (start),
    .mode_c      (mode_c),
    .din_a       (din_a),
    .din_b       (din_b),
    .cipher_fire (cipher_fire),
    .mul_load    (mul_load),
    .busy        (busy),
    .mcand       (mcand),
    .bsel        (bsel),
    .done        (done_int)
  );

  pca_cell_array #(.WIDTH(WIDTH)) u_array (
    .cipher_en (!busy),
    .rules     (rules),
    .blk       (din_a),
    .acc       (acc_q),
    .poly      (poly),
    .mcand     (mcand),
    .bsel      (bsel),
    .nxt       (cell_nxt)
  );

  always_comb begin
    acc_en = cipher_fire || mul_load || busy;
    if (mul_load) acc_d = '0;
    else          acc_d = cell_nxt;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign dout = acc_q;
  assign done = done_int;

  // R6: the end of a multiply always raises done
  p_done_at_end_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $fell(busy) |-> done_int);

  // R8: with nothing accepted and nothing running, the result holds
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!cipher_fire && !mul_load && !busy) |=> $stable(acc_q));

  // R8: done never stays high without a fresh cipher block behind it
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (done_int && !cipher_fire) |=> !done_int);

endmodule

// File: tb/pca_datapath_bench.sv
module pca_datapath_bench;
  localparam int W  = 4;
  localparam int CW = 2 * W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, cfg_we, cfg_sel, mode_c, start;
  logic [CW-1:0] cfg_data;
  logic [W-1:0]  din_a, din_b, dout;
  logic          done;

  int vectors = 0;
  int misses  = 0;

  pca_datapath #(.WIDTH(W)) u_pca_datapath (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .mode_c(mode_c), .start(start),
    .din_a(din_a), .din_b(din_b), .dout(dout), .done(done)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [W-1:0] model_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic [W-1:0] p);
    logic [2*W-2:0] prod;
    prod = '0;
    for (int j = 0; j < W; j++)
      if (b[j]) prod ^= (2*W-1)'(a) << j;
    for (int i = 2*W-2; i >= W; i--)
      if (prod[i]) prod ^= (2*W-1)'({1'b1, p}) << (i - W);
    return prod[W-1:0];
  endfunction

  function automatic logic [W-1:0] model_ca(input logic [W-1:0] x, input logic [CW-1:0] rw);
    logic [W-1:0] y;
    for (int i = 0; i < W; i++) begin
      logic l, r;
      l = (i < W-1) ? x[i+1] : 1'b0;
      r = (i > 0)   ? x[i-1] : 1'b0;
      case (rw[2*i +: 2])
        2'b00: y[i] = ~x[i];
        2'b01: y[i] = ~(x[i] ^ r);
        2'b10: y[i] = ~(l ^ x[i]);
        default: y[i] = x[i];
      endcase
    end
    return y;
  endfunction

  function automatic logic [CW-1:0] rot(input logic [CW-1:0] rw);
    return {rw[CW-3:0], rw[CW-1:CW-2]};
  endfunction

  task automatic write_cfg(input logic sel, input logic [CW-1:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = val;
    tick();
    cfg_we = 1'b0;
  endtask

  // disturb: pulse start with other data and flip mode mid-multiply (R7, R9)
  task automatic do_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] p, input bit disturb, input bit chk_timing);
    mode_c = 1'b0; din_a = a; din_b = b; start = 1'b1;
    tick();
    start = 1'b0;
    for (int k = 1; k < W; k++) begin
      if (disturb && k == 1) begin
        start = 1'b1; mode_c = 1'b1; din_a = ~a; din_b = ~b;
      end
      tick();
      start = 1'b0; mode_c = 1'b0;
      if (chk_timing && k == W-1) check("R6 done early", {{(W-1){1'b0}}, done}, '0);
    end
    tick();
    check(disturb ? "R7/R9 product with disturbance" : "R6 product", dout, model_mul(a, b, p));
    if (chk_timing) begin
      check("R6 done", {{(W-1){1'b0}}, done}, {{(W-1){1'b0}}, 1'b1});
      tick();
      check("R8 done single", {{(W-1){1'b0}}, done}, '0);
      check("R8 hold", dout, model_mul(a, b, p));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [CW-1:0] rw;
    logic [W-1:0]  last;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_data = '0;
    mode_c = 1'b0; start = 1'b0; din_a = '0; din_b = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    check("R1 dout reset", dout, '0);
    check("R1 done reset", {{(W-1){1'b0}}, done}, '0);

    // R1: reset rule codes are 00 (invert every cell)
    mode_c = 1'b1; din_a = 4'b1010; start = 1'b1;
    tick();
    start = 1'b0;
    check("R1 reset rules", dout, 4'b0101);
    // R1: reset polynomial 0 means reduction by x^4 alone
    do_mul(4'hF, 4'hF, 4'h0, 1'b0, 1'b1);

    // R6 / R5: exhaustive multiply sweep over all polynomials
    for (int p = 0; p < 16; p++) begin
      write_cfg(1'b1, CW'(p));
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          do_mul(W'(a), W'(b), W'(p), 1'b0, (a == b));
    end

    // R7 / R9: disturbed multiplies; rule word must not rotate
    write_cfg(1'b1, CW'(4'h3));
    write_cfg(1'b0, CW'(8'b11_10_01_00));
    for (int a = 1; a < 16; a += 3)
      do_mul(W'(a), W'(a * 7), 4'h3, 1'b1, 1'b1);
    mode_c = 1'b1; din_a = 4'b0110; start = 1'b1;
    tick();
    start = 1'b0;
    check("R7 rules unrotated", dout, model_ca(4'b0110, 8'b11_10_01_00));

    // R2 / R3 / R4: every rule word, four back-to-back blocks
    for (int r = 0; r < 256; r++) begin
      write_cfg(1'b0, CW'(r));
      rw = CW'(r);
      mode_c = 1'b1; start = 1'b1;
      for (int k = 0; k < 4; k++) begin
        din_a = W'(r + k * 5);
        tick();
        check("R2/R4 cipher block", dout, model_ca(W'(r + k * 5), rw));
        check("R3 done", {{(W-1){1'b0}}, done}, {{(W-1){1'b0}}, 1'b1});
        rw = rot(rw);
      end
      last = dout;
      start = 1'b0; din_a = ~din_a;
      tick();
      check("R8 done clear", {{(W-1){1'b0}}, done}, '0);
      check("R8 cipher hold", dout, last);
    end

    // R5: rule write wins over a same-cycle rotation
    write_cfg(1'b0, CW'(8'b00_00_00_00));
    mode_c = 1'b1; start = 1'b1; din_a = 4'b0011;
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_data = 8'b11_11_11_11;
    tick();
    cfg_we = 1'b0;
    check("R5 block before write", dout, 4'b1100);
    din_a = 4'b1001;
    tick();
    start = 1'b0;
    check("R5 write beats rotation", dout, 4'b1001);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule